// File: doc/BRIEF.md
# Vertical Line-Rate Scaling Accumulator

This block steers vertical resampling of a progressive graphics frame onto a television frame whose total line count differs. There is no frame store, so input and output frames run at the same rate. The line ratio is therefore fixed by the total line counts, blanking included. The active-line ratio has to match the same figure. One 16-bit fractional coefficient sets the ratio. A mode bit selects how the coefficient is read. When shrinking, the coefficient is the ratio itself, scaled by 65536. When enlarging, it is only the part of the ratio above one, scaled by 65536. For example, 788 source lines onto a 525-line output frame gives a ratio near 0.6662 and a coefficient of 43663.

On each incoming line the block adds the coefficient into a phase accumulator with one carry bit. One cycle later it reports four things: whether the line yields an output line, whether it also yields a second one, which pair of stored source lines the output blends, and the blend weight. Every source line passes through the same accumulator, so each contributes with equal weight and no line is simply dropped or copied. Interlacing is applied to the progressive output downstream of this stage. The block also keeps running counts of input and output lines for the current frame.

A frame-start pulse restarts the accumulator and both counts. A coefficient or mode written through the write port is held back until the next frame start.

Top module: `vscale_accum`

## Requirements
- R1: After reset, out_fire, out_twin, out_weight, out_src_hi, out_src_lo, in_count and out_count are all zero.
- R2: Shrink mode (mode bit 0): each input line adds the coefficient to a 17-bit accumulator, and an output line is produced only when the addition carries into bit 16. Over N lines from a restart, the output count is floor(N*coef/65536); 788 lines at 43663 give 525.
- R3: Enlarge mode (mode bit 1): every input line produces one output line. A carry out of the same addition adds a second output line (out_twin) from the same source pair, so N lines give N + floor(N*coef/65536). out_twin is never set without out_fire, and it is never set in shrink mode.
- R4: out_weight is bits [15:8] of the accumulator fraction after the addition made for that line.
- R5: out_src_hi is the zero-based index of the current input line within the frame. out_src_lo is that index minus one, held at 0 for the first line.
- R6: A frame_start pulse clears the accumulator and both counts. A line_in in the same cycle is taken as line 0 of the new frame.
- R7: A coefficient and mode written with cfg_we take effect only at the next frame_start. Lines before it keep using the previous values.
- R8: in_count and out_count give the input lines and the output lines (out_fire plus out_twin) seen since the last frame_start.
- R9: The line outputs are registered and appear in the cycle after line_in. With no line_in, out_fire and out_twin are 0 in the following cycle.
- R10: At the end of a frame, out_count is within one line of in_count times the programmed ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the pending coefficient and mode |
| cfg_coef | input | 16 | Coefficient value to write |
| cfg_up | input | 1 | Mode to write: 1 enlarge, 0 shrink |
| frame_start | input | 1 | Frame boundary pulse |
| line_in | input | 1 | One pulse per incoming source line |
| out_fire | output | 1 | An output line is produced for the last input line |
| out_twin | output | 1 | A second output line is produced from the same pair |
| out_weight | output | 8 | Blend weight toward the newer source line |
| out_src_hi | output | 11 | Index of the newer source line of the pair |
| out_src_lo | output | 11 | Index of the older source line of the pair |
| in_count | output | 11 | Input lines in the current frame |
| out_count | output | 12 | Output lines in the current frame |

## Verification
A corrupt accumulator phase shows at the ports on the very next line. out_weight no longer follows the running sum, and out_fire or out_twin moves one line early or late. Across a whole frame, this also drifts the final out_count away from floor(N*coef/65536). A stale or early-loaded coefficient shows as a wrong line count in the frame after the write. A counter that fails to restart shows in the cycle after frame_start as nonzero counts and a source index that does not begin at 0.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

  typedef enum logic {
    VS_SHRINK  = 1'b0,
    VS_ENLARGE = 1'b1
  } vs_mode_e;

endpackage

// File: rtl/vscale_coef_regs.sv
module vscale_coef_regs
  import vscale_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FRAC_W-1:0] wr_coef,
  input  logic              wr_up,
  input  logic              restart,
  output logic [FRAC_W-1:0] eff_coef,
  output vs_mode_e          eff_mode,
  output vs_mode_e          act_mode
);

  logic [FRAC_W-1:0] pend_coef_q, pend_coef_d;
  vs_mode_e          pend_mode_q, pend_mode_d;
  logic [FRAC_W-1:0] act_coef_q, act_coef_d;
  vs_mode_e          act_mode_q, act_mode_d;

  always_comb begin
    pend_coef_d = pend_coef_q;
    pend_mode_d = pend_mode_q;
    if (wr_en) begin
      pend_coef_d = wr_coef;
      pend_mode_d = wr_up ? VS_ENLARGE : VS_SHRINK;
    end
    act_coef_d = act_coef_q;
    act_mode_d = act_mode_q;
    if (restart) begin
      act_coef_d = pend_coef_q;
      act_mode_d = pend_mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_coef_q <= '0;
      pend_mode_q <= VS_SHRINK;
      act_coef_q  <= '0;
      act_mode_q  <= VS_SHRINK;
    end else begin
      pend_coef_q <= pend_coef_d;
      pend_mode_q <= pend_mode_d;
      act_coef_q  <= act_coef_d;
      act_mode_q  <= act_mode_d;
    end
  end

  // A line coinciding with restart already uses the freshly loaded values.
  assign eff_coef = restart ? pend_coef_q : act_coef_q;
  assign eff_mode = restart ? pend_mode_q : act_mode_q;
  assign act_mode = act_mode_q;

endmodule

// File: rtl/vscale_phase_acc.sv
module vscale_phase_acc
  import vscale_pkg::*;
#(
  parameter int FRAC_W   = 16,
  parameter int WEIGHT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                restart,
  input  logic [FRAC_W-1:0]   coef,
  input  vs_mode_e            mode,
  output logic                fire,
  output logic                twin,
  output logic [WEIGHT_W-1:0] weight
);

  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q, acc_d, base;
  logic [SUM_W-1:0]  sum;
  logic              carry;

  always_comb begin
    base  = restart ? '0 : acc_q;
    sum   = {1'b0, base} + {1'b0, coef};
    carry = sum[FRAC_W];
    acc_d = step ? sum[FRAC_W-1:0] : base;
    fire  = step && ((mode == VS_ENLARGE) || carry);
    twin  = step && (mode == VS_ENLARGE) && carry;
  end

  generate
    if (WEIGHT_W >= FRAC_W) begin : g_wide_weight
      assign weight = {sum[FRAC_W-1:0], {(WEIGHT_W-FRAC_W){1'b0}}};
    end else begin : g_top_weight
      assign weight = sum[FRAC_W-1 -: WEIGHT_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/vscale_line_count.sv
module vscale_line_count #(
  parameter int LINE_W    = 11,
  parameter bit SAT_COUNT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic              fire,
  input  logic              twin,
  output logic [LINE_W-1:0] line_idx,
  output logic [LINE_W-1:0] in_cnt,
  output logic [LINE_W:0]   out_cnt
);

  localparam int OUT_W = LINE_W + 1;

  logic [LINE_W-1:0] in_q, in_d, in_base;
  logic [OUT_W-1:0]  out_q, out_d, out_base, out_add;
  logic [OUT_W:0]    out_wide;
  logic [LINE_W:0]   in_wide;

  always_comb begin
    in_base  = restart ? '0 : in_q;
    out_base = restart ? '0 : out_q;
    out_add  = {{(OUT_W-1){1'b0}}, fire} + {{(OUT_W-1){1'b0}}, twin};
    in_wide  = {1'b0, in_base} + {{LINE_W{1'b0}}, step};
    out_wide = {1'b0, out_base} + {1'b0, out_add};
  end

  generate
    if (SAT_COUNT) begin : g_sat
      assign in_d  = in_wide[LINE_W]  ? {LINE_W{1'b1}} : in_wide[LINE_W-1:0];
      assign out_d = out_wide[OUT_W]  ? {OUT_W{1'b1}}  : out_wide[OUT_W-1:0];
    end else begin : g_wrap
      logic unused_carry;
      assign unused_carry = in_wide[LINE_W] ^ out_wide[OUT_W];
      assign in_d  = in_wide[LINE_W-1:0];
      assign out_d = out_wide[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  assign line_idx = in_base;
  assign in_cnt   = in_q;
  assign out_cnt  = out_q;

endmodule

// File: rtl/vscale_accum.sv
module vscale_accum
  import vscale_pkg::*;
#(
  parameter int FRAC_W   = 16,
  parameter int WEIGHT_W = 8,
  parameter int LINE_W   = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [FRAC_W-1:0]   cfg_coef,
  input  logic                cfg_up,
  input  logic                frame_start,
  input  logic                line_in,
  output logic                out_fire,
  output logic                out_twin,
  output logic [WEIGHT_W-1:0] out_weight,
  output logic [LINE_W-1:0]   out_src_hi,
  output logic [LINE_W-1:0]   out_src_lo,
  output logic [LINE_W-1:0]   in_count,
  output logic [LINE_W:0]     out_count
);

  logic [FRAC_W-1:0]   eff_coef;
  vs_mode_e            eff_mode;
  vs_mode_e            act_mode;
  logic                mode_act_up;
  logic                fire_c, twin_c;
  logic [WEIGHT_W-1:0] weight_c;
  logic [LINE_W-1:0]   idx_c, lo_c;

  vscale_coef_regs #(.FRAC_W(FRAC_W)) u_coef (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_coef  (cfg_coef),
    .wr_up    (cfg_up),
    .restart  (frame_start),
    .eff_coef (eff_coef),
    .eff_mode (eff_mode),
    .act_mode (act_mode)
  );

  vscale_phase_acc #(.FRAC_W(FRAC_W), .WEIGHT_W(WEIGHT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (line_in),
    .restart (frame_start),
    .coef    (eff_coef),
    .mode    (eff_mode),
    .fire    (fire_c),
    .twin    (twin_c),
    .weight  (weight_c)
  );

  vscale_line_count #(.LINE_W(LINE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (line_in),
    .restart  (frame_start),
    .fire     (fire_c),
    .twin     (twin_c),
    .line_idx (idx_c),
    .in_cnt   (in_count),
    .out_cnt  (out_count)
  );

  assign mode_act_up = (act_mode == VS_ENLARGE);

  // Event register: next state then flops.
  logic                fire_d, twin_d;
  logic [WEIGHT_W-1:0] weight_q, weight_d;
  logic [LINE_W-1:0]   hi_q, hi_d, lo_q, lo_d;
  logic                fire_q, twin_q;

  always_comb begin
    lo_c     = (idx_c == '0) ? '0 : idx_c - 1'b1;
    fire_d   = fire_c;
    twin_d   = twin_c;
    weight_d = weight_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    if (line_in) begin
      weight_d = weight_c;
      hi_d     = idx_c;
      lo_d     = lo_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q   <= 1'b0;
      twin_q   <= 1'b0;
      weight_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      fire_q   <= fire_d;
      twin_q   <= twin_d;
      weight_q <= weight_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
    end
  end

  assign out_fire   = fire_q;
  assign out_twin   = twin_q;
  assign out_weight = weight_q;
  assign out_src_hi = hi_q;
  assign out_src_lo = lo_q;

endmodule

// File: rtl/vscale_accum_chk.sv
module vscale_accum_chk #(
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_in,
  input logic              mode_act_up,
  input logic              out_fire,
  input logic              out_twin,
  input logic [LINE_W-1:0] in_count,
  input logic [LINE_W:0]   out_count
);

  assert_twin_needs_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_twin |-> out_fire);

  assert_idle_no_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_in |=> (!out_fire && !out_twin));

  assert_enlarge_every_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_in && !frame_start && mode_act_up) |=> out_fire);

  assert_shrink_no_twin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_in && !frame_start && !mode_act_up) |=> !out_twin);

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !line_in) |=> (in_count == '0 && out_count == '0));

  assert_out_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (out_count == $past(out_count)
                      + {{LINE_W{1'b0}}, out_fire} + {{LINE_W{1'b0}}, out_twin}));

  assert_in_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (in_count == $past(in_count) + {{(LINE_W-1){1'b0}}, $past(line_in)}));

  assert_shrink_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_act_up |-> (out_count <= {1'b0, in_count}));

endmodule

bind vscale_accum vscale_accum_chk #(.LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .line_in     (line_in),
  .mode_act_up (mode_act_up),
  .out_fire    (out_fire),
  .out_twin    (out_twin),
  .in_count    (in_count),
  .out_count   (out_count)
);

// File: tb/vscale_accum_tb.sv
module vscale_accum_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_up, frame_start, line_in;
  logic [15:0] cfg_coef;
  logic        out_fire, out_twin;
  logic [7:0]  out_weight;
  logic [10:0] out_src_hi, out_src_lo, in_count;
  logic [11:0] out_count;

  int checks = 0;
  int errors = 0;
  int seen   = 0;

  always #4 clk = ~clk;

  vscale_accum u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_coef(cfg_coef), .cfg_up(cfg_up),
    .frame_start(frame_start), .line_in(line_in), .out_fire(out_fire),
    .out_twin(out_twin), .out_weight(out_weight), .out_src_hi(out_src_hi),
    .out_src_lo(out_src_lo), .in_count(in_count), .out_count(out_count)
  );

  // {mode, coef, input lines, expected output lines}
  localparam int NVEC = 8;
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 16'd43663, 11'd788, 12'd525},
    {1'b0, 16'd32768, 11'd100, 12'd50},
    {1'b1, 16'd0,     11'd50,  12'd50},
    {1'b1, 16'd32768, 11'd40,  12'd60},
    {1'b1, 16'd65535, 11'd30,  12'd59},
    {1'b0, 16'd65535, 11'd10,  12'd9},
    {1'b0, 16'd0,     11'd10,  12'd0},
    {1'b1, 16'd21845, 11'd90,  12'd119}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic up, input logic [15:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_up = up; cfg_coef = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // Drives one line; outputs are sampled at the next falling edge.
  task automatic one_line(input logic with_frame);
    @(negedge clk);
    line_in = 1'b1; frame_start = with_frame;
    @(negedge clk);
    line_in = 1'b0; frame_start = 1'b0;
    seen += int'(out_fire) + int'(out_twin);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_up = 1'b0; cfg_coef = '0;
    frame_start = 1'b0; line_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 fire", out_fire, 0);
    check("R1 twin", out_twin, 0);
    check("R1 weight", out_weight, 0);
    check("R1 src", {out_src_hi, out_src_lo}, 0);
    check("R1 counts", {in_count, out_count}, 0);

    // Vector walk: R2 R3 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      logic        up;
      logic [15:0] c;
      int          n, e;
      longint      diff;
      up = VEC[v][39]; c = VEC[v][38:23]; n = int'(VEC[v][22:12]); e = int'(VEC[v][11:0]);
      write_cfg(up, c);
      pulse_frame();
      check("R6 in_count after frame_start", in_count, 0);
      seen = 0;
      for (int i = 0; i < n; i++) one_line(1'b0);
      check(up ? "R3 enlarge line total" : "R2 shrink line total", seen, e);
      check("R8 in_count", in_count, n);
      check("R8 out_count", out_count, e);
      diff = longint'(out_count) * 65536 - (longint'(n) * c + (up ? longint'(n) * 65536 : 0));
      check("R10 within one line", (diff > -65536 && diff < 65536) ? 1 : 0, 1);
    end

    // R4 R5 R9 shrink weights: coef 0xAA8F
    write_cfg(1'b0, 16'hAA8F);
    pulse_frame();
    one_line(1'b0);
    check("R9 no fire first line", out_fire, 0);
    check("R4 weight line0", out_weight, 8'hAA);
    check("R5 hi line0", out_src_hi, 0);
    check("R5 lo line0", out_src_lo, 0);
    one_line(1'b0);
    check("R2 fire line1", out_fire, 1);
    check("R4 weight line1", out_weight, 8'h55);
    check("R5 hi line1", out_src_hi, 1);
    check("R5 lo line1", out_src_lo, 0);
    @(negedge clk);
    check("R9 idle no fire", out_fire, 0);

    // R3 R4 enlarge: coef 0xC000
    write_cfg(1'b1, 16'hC000);
    pulse_frame();
    one_line(1'b0);
    check("R3 fire line0", {out_fire, out_twin}, 2'b10);
    check("R4 weight up line0", out_weight, 8'hC0);
    one_line(1'b0);
    check("R3 twin line1", {out_fire, out_twin}, 2'b11);
    check("R4 weight up line1", out_weight, 8'h80);
    one_line(1'b0);
    check("R5 lo line2", out_src_lo, 1);
    check("R8 out_count up", out_count, 5);

    // R6 coincident frame_start and line, R7 deferred write
    write_cfg(1'b0, 16'h8000);
    one_line(1'b1);
    check("R6 coincident in_count", in_count, 1);
    check("R6 coincident out_count", out_count, 0);
    check("R6 coincident hi", out_src_hi, 0);
    check("R6 shrink applied at coincident line", out_fire, 0);
    one_line(1'b0);
    check("R6 fire line1", out_fire, 1);
    write_cfg(1'b1, 16'h0000);
    one_line(1'b0);
    check("R7 mid-frame write ignored", out_fire, 0);
    one_line(1'b0);
    check("R7 old coef still used", out_count, 2);
    check("R7 in_count", in_count, 4);
    pulse_frame();
    check("R6 counts cleared", {in_count, out_count}, 0);
    one_line(1'b0);
    check("R7 new mode at frame start", {out_fire, out_twin}, 2'b10);
    one_line(1'b0);
    one_line(1'b0);
    check("R7 new frame out_count", out_count, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule